// File: doc/BRIEF.md
# Five-Stage Pipelined Core With Retirement Register

This block is a small in-order processor core for an eight-register, 32-bit word instruction set. It runs add, nor, load, store, branch-if-equal, halt and no-operation through five stages (fetch, decode, execute, memory, write-back). A sixth register after write-back keeps the retiring instruction and its result for one more cycle. Because of that sixth register, the register file never has to pass a value that is written in a cycle to a read in the same cycle. Operand values reach the execute stage from the three later pipeline registers. The block stalls only when an instruction uses the result of the load just ahead of it. Branches are assumed not taken and are resolved in the memory stage.

The program image is a parameter. At reset it is copied into the data memory, and the instruction memory reads the same image and is never written. The core runs from reset until a halt instruction reaches the memory/write-back register. From then on all state is frozen and a flag reports the halt. Every pipeline register is visible at the ports, as are the program counter and the count of executed cycles. A surrounding test environment can therefore follow the machine cycle by cycle.

Top module: `pipe_core`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the program counter and cycle count are zero and all five pipeline instruction fields hold the no-op word 0x01C00000.
- R2: An instruction word is decoded as follows. The opcode is in bits 24:22, with add=0, nor=1, load=2, store=3, branch=4, halt=6 and no-op=7. Opcode 5 acts as a no-op. The first source register is in bits 21:19 and the second register is in bits 18:16. The offset is in bits 15:0. Add and nor write the register named in bits 2:0, and a load writes the register named in bits 18:16.
- R3: Fetch writes the program counter plus one into the fetch/decode register and advances the program counter. Decode places the offset, sign-extended to 32 bits, in the decode/execute register.
- R4: Execute takes each operand from the newest pipeline register whose instruction writes that register number. Execute/memory has the highest priority, then memory/write-back, then the retirement register, and finally the value read in decode.
- R5: When a load is in decode/execute and the instruction in fetch/decode reads the load's destination, the core inserts exactly one bubble (no-op) into decode/execute. For this rule, add, nor, branch and store read both source fields and a load reads only the first. During that cycle the program counter and fetch/decode hold their values.
- R6: A store writes the second register's value to data memory at first register plus offset. A later load from that address returns the stored value.
- R7: A branch whose two operands are equal is taken in the memory stage. The program counter is loaded with the branch's PC+1 plus offset, and the three younger instructions are replaced with the no-op word.
- R8: The halted output is high exactly when the memory/write-back register holds a halt. While it is high, the program counter, the cycle count and all pipeline registers stay unchanged.
- R9: Each cycle the retirement register takes the instruction and write data that memory/write-back held in the previous cycle.
- R10: The cycle count goes up by one on every clock edge while neither reset nor halted is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; reloads the image |
| halted | output | 1 | Halt instruction is in memory/write-back |
| cycles | output | 32 | Number of cycles executed |
| pc | output | 32 | Program counter |
| ifid_instr | output | 32 | Fetch/decode instruction |
| ifid_pcp1 | output | 32 | Fetch/decode PC+1 |
| idex_instr | output | 32 | Decode/execute instruction |
| idex_pcp1 | output | 32 | Decode/execute PC+1 |
| idex_rega | output | 32 | Decode/execute first register value |
| idex_regb | output | 32 | Decode/execute second register value |
| idex_offset | output | 32 | Decode/execute sign-extended offset |
| exmem_instr | output | 32 | Execute/memory instruction |
| exmem_target | output | 32 | Execute/memory branch target |
| exmem_alu | output | 32 | Execute/memory ALU result |
| exmem_regb | output | 32 | Execute/memory store data |
| memwb_instr | output | 32 | Memory/write-back instruction |
| memwb_data | output | 32 | Memory/write-back write data |
| wbend_instr | output | 32 | Retirement register instruction |
| wbend_data | output | 32 | Retirement register write data |

## Verification
Several internal faults appear at the ports as a wrong value in the retirement register five or six cycles after the faulty instruction is fetched. These include a wrong forwarding source, a missing bubble, a register file that bypasses writes, and a store that never reaches memory. A wrong stall, branch redirect or flush also shows as a program counter that differs in the very next cycle. A late or early halt shows in the halted flag and the cycle count. The bench program therefore has a load followed at once by its use, a forward from the retirement register, a store followed by a load of the same address, a taken branch that skips a halt, and two in-flight writers of the same register. It then compares the program counter and the retirement register in every cycle.

// File: rtl/pipe_core.sv
module pipe_core #(
  parameter int MEM_WORDS = 64,
  parameter logic [MEM_WORDS*32-1:0] IMAGE = '0
) (
  input  logic        clk,
  input  logic        rst,
  output logic        halted,
  output logic [31:0] cycles,
  output logic [31:0] pc,
  output logic [31:0] ifid_instr,
  output logic [31:0] ifid_pcp1,
  output logic [31:0] idex_instr,
  output logic [31:0] idex_pcp1,
  output logic [31:0] idex_rega,
  output logic [31:0] idex_regb,
  output logic [31:0] idex_offset,
  output logic [31:0] exmem_instr,
  output logic [31:0] exmem_target,
  output logic [31:0] exmem_alu,
  output logic [31:0] exmem_regb,
  output logic [31:0] memwb_instr,
  output logic [31:0] memwb_data,
  output logic [31:0] wbend_instr,
  output logic [31:0] wbend_data
);
  localparam int AW = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;
  localparam logic [31:0] NOP_W = 32'h01C0_0000;
  localparam logic [2:0] OP_ADD = 3'd0, OP_NOR = 3'd1, OP_LW = 3'd2,
                         OP_SW = 3'd3, OP_BEQ = 3'd4, OP_HALT = 3'd6;

  function automatic logic writes(input logic [31:0] w);
    return w[24:22] == OP_ADD || w[24:22] == OP_NOR || w[24:22] == OP_LW;
  endfunction

  function automatic logic [2:0] dest(input logic [31:0] w);
    return (w[24:22] == OP_LW) ? w[18:16] : w[2:0];
  endfunction

  logic [31:0] rf   [8];
  logic [31:0] dmem [MEM_WORDS];

  wire [31:0] fetch_w = IMAGE[pc[AW-1:0]*32 +: 32];
  assign halted = memwb_instr[24:22] == OP_HALT;

  wire [2:0] if_op = ifid_instr[24:22];
  wire use_a = if_op == OP_ADD || if_op == OP_NOR || if_op == OP_BEQ ||
               if_op == OP_SW || if_op == OP_LW;
  wire use_b = if_op == OP_ADD || if_op == OP_NOR || if_op == OP_BEQ || if_op == OP_SW;
  wire stall = idex_instr[24:22] == OP_LW &&
               ((use_a && ifid_instr[21:19] == idex_instr[18:16]) ||
                (use_b && ifid_instr[18:16] == idex_instr[18:16]));
  wire taken = exmem_instr[24:22] == OP_BEQ && exmem_alu == 32'd0;

  function automatic logic [31:0] pick(input logic [2:0] r, input logic [31:0] dflt,
                                       input logic [31:0] i1, input logic [31:0] d1,
                                       input logic [31:0] i2, input logic [31:0] d2,
                                       input logic [31:0] i3, input logic [31:0] d3);
    if (writes(i1) && dest(i1) == r) return d1;
    if (writes(i2) && dest(i2) == r) return d2;
    if (writes(i3) && dest(i3) == r) return d3;
    return dflt;
  endfunction

  wire [31:0] op_a = pick(idex_instr[21:19], idex_rega, exmem_instr, exmem_alu,
                          memwb_instr, memwb_data, wbend_instr, wbend_data);
  wire [31:0] op_b = pick(idex_instr[18:16], idex_regb, exmem_instr, exmem_alu,
                          memwb_instr, memwb_data, wbend_instr, wbend_data);

  logic [31:0] alu_n, mem_wd;
  always_comb begin
    case (idex_instr[24:22])
      OP_ADD:       alu_n = op_a + op_b;
      OP_NOR:       alu_n = ~(op_a | op_b);
      OP_LW, OP_SW: alu_n = op_a + idex_offset;
      OP_BEQ:       alu_n = op_a - op_b;
      default:      alu_n = exmem_alu;
    endcase
    case (exmem_instr[24:22])
      OP_ADD, OP_NOR: mem_wd = exmem_alu;
      OP_LW:          mem_wd = dmem[exmem_alu[AW-1:0]];
      default:        mem_wd = memwb_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cycles <= '0; pc <= '0;
      ifid_instr <= NOP_W; ifid_pcp1 <= '0;
      idex_instr <= NOP_W; idex_pcp1 <= '0; idex_rega <= '0; idex_regb <= '0; idex_offset <= '0;
      exmem_instr <= NOP_W; exmem_target <= '0; exmem_alu <= '0; exmem_regb <= '0;
      memwb_instr <= NOP_W; memwb_data <= '0;
      wbend_instr <= NOP_W; wbend_data <= '0;
      for (int k = 0; k < 8; k++) rf[k] <= '0;
      for (int k = 0; k < MEM_WORDS; k++) dmem[k] <= IMAGE[k*32 +: 32];
    end else if (!halted) begin
      cycles <= cycles + 32'd1;
      if (taken) begin
        pc <= exmem_target;
        ifid_instr <= NOP_W;
      end else if (!stall) begin
        pc <= pc + 32'd1;
        ifid_instr <= fetch_w;
        ifid_pcp1 <= pc + 32'd1;
      end
      idex_instr  <= (taken || stall) ? NOP_W : ifid_instr;
      idex_pcp1   <= ifid_pcp1;
      idex_rega   <= rf[ifid_instr[21:19]];
      idex_regb   <= rf[ifid_instr[18:16]];
      idex_offset <= {{16{ifid_instr[15]}}, ifid_instr[15:0]};
      exmem_instr  <= taken ? NOP_W : idex_instr;
      exmem_target <= idex_pcp1 + idex_offset;
      exmem_alu    <= alu_n;
      exmem_regb   <= op_b;
      memwb_instr <= exmem_instr;
      memwb_data  <= mem_wd;
      if (exmem_instr[24:22] == OP_SW) dmem[exmem_alu[AW-1:0]] <= exmem_regb;
      if (writes(memwb_instr)) rf[dest(memwb_instr)] <= memwb_data;
      wbend_instr <= memwb_instr;
      wbend_data  <= memwb_data;
    end
  end
endmodule

module pipe_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        halted,
  input logic [31:0] cycles,
  input logic [31:0] pc,
  input logic [31:0] ifid_instr,
  input logic [31:0] idex_instr,
  input logic [31:0] exmem_instr,
  input logic [31:0] exmem_target,
  input logic [31:0] exmem_alu,
  input logic [31:0] memwb_instr,
  input logic [31:0] wbend_instr
);
  localparam logic [31:0] NOP_W = 32'h01C0_0000;

  assert_reset_state_R1: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (pc == 0 && cycles == 0 && ifid_instr == NOP_W &&
      idex_instr == NOP_W && exmem_instr == NOP_W && memwb_instr == NOP_W && wbend_instr == NOP_W));

  assert_load_use_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    (!halted && idex_instr[24:22] == 3'd2 && ifid_instr[24:22] == 3'd0 &&
     ifid_instr[21:19] == idex_instr[18:16] && exmem_instr[24:22] != 3'd4)
    |=> (idex_instr == NOP_W && $stable(pc) && $stable(ifid_instr)));

  assert_branch_flush_R7: assert property (@(posedge clk) disable iff (rst)
    (!halted && exmem_instr[24:22] == 3'd4 && exmem_alu == 0)
    |=> (ifid_instr == NOP_W && idex_instr == NOP_W && exmem_instr == NOP_W &&
         pc == $past(exmem_target)));

  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(cycles) && $stable(wbend_instr)));

  assert_retire_copy_R9: assert property (@(posedge clk) disable iff (rst)
    (!halted) |=> wbend_instr == $past(memwb_instr));

  assert_cycle_count_R10: assert property (@(posedge clk) disable iff (rst)
    (!halted) |=> cycles == $past(cycles) + 32'd1);
endmodule

bind pipe_core pipe_core_chk u_chk (
  .clk(clk), .rst(rst), .halted(halted), .cycles(cycles), .pc(pc),
  .ifid_instr(ifid_instr), .idex_instr(idex_instr), .exmem_instr(exmem_instr),
  .exmem_target(exmem_target), .exmem_alu(exmem_alu),
  .memwb_instr(memwb_instr), .wbend_instr(wbend_instr));

// File: tb/test_pipe_core.sv
module test_pipe_core;
  localparam int W = 16;
  localparam logic [31:0] NOP_W = 32'h01C0_0000;
  localparam logic [W*32-1:0] PROG = {
    32'h0, 32'h0, 32'h0, 32'h5,
    32'h01800000, 32'h00360007, 32'h00090006, 32'h00210006,
    32'h01800000, 32'h0009FFFF, 32'h01000002, 32'h0084000D,
    32'h00C3000D, 32'h004A0003, 32'h00090002, 32'h0081000C};

  // {check data, pc, retired instr, retired data}
  localparam logic [96:0] VEC [18] = '{
    {1'b0, 32'd0,  NOP_W, 32'd0},
    {1'b0, 32'd1,  NOP_W, 32'd0},
    {1'b0, 32'd2,  NOP_W, 32'd0},
    {1'b0, 32'd2,  NOP_W, 32'd0},
    {1'b0, 32'd3,  NOP_W, 32'd0},
    {1'b1, 32'd4,  32'h0081000C, 32'd5},
    {1'b0, 32'd5,  NOP_W, 32'd0},
    {1'b1, 32'd6,  32'h00090002, 32'd10},
    {1'b1, 32'd7,  32'h004A0003, 32'hFFFFFFF0},
    {1'b0, 32'd8,  32'h00C3000D, 32'd0},
    {1'b1, 32'd8,  32'h0084000D, 32'hFFFFFFF0},
    {1'b0, 32'd9,  32'h01000002, 32'd0},
    {1'b0, 32'd10, NOP_W, 32'd0},
    {1'b0, 32'd11, NOP_W, 32'd0},
    {1'b0, 32'd12, NOP_W, 32'd0},
    {1'b1, 32'd13, 32'h00210006, 32'hFFFFFFF5},
    {1'b1, 32'd14, 32'h00090006, 32'd10},
    {1'b1, 32'd15, 32'h00360007, 32'd20}};

  logic clk = 0, rst = 1;
  logic halted;
  logic [31:0] cycles, pc, ifid_instr, ifid_pcp1, idex_instr, idex_pcp1, idex_rega,
               idex_regb, idex_offset, exmem_instr, exmem_target, exmem_alu, exmem_regb,
               memwb_instr, memwb_data, wbend_instr, wbend_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pipe_core #(.MEM_WORDS(W), .IMAGE(PROG)) i_pipe_core (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc in reset", pc, 0);
    chk("R1 memwb noop in reset", memwb_instr, NOP_W);
    rst = 0;
    #1;
    chk("R1 cycles", cycles, 0);
    chk("R1 ifid noop", ifid_instr, NOP_W);
    chk("R1 exmem noop", exmem_instr, NOP_W);
    for (int n = 0; n < 18; n++) begin
      if (n > 0) @(negedge clk);
      chk($sformatf("R3 pc state %0d", n), pc, VEC[n][95:64]);
      chk($sformatf("%s retired instr state %0d", (n >= 12 && n <= 14) ? "R7" : "R9", n),
          wbend_instr, VEC[n][63:32]);
      if (VEC[n][96])
        chk($sformatf("%s retired data state %0d", n == 10 ? "R6" : (n == 8 ? "R2" : "R4"), n),
            wbend_data, VEC[n][31:0]);
      chk($sformatf("R8 halted state %0d", n), {31'd0, halted}, {31'd0, n == 17});
      chk($sformatf("R10 cycles state %0d", n), cycles, n);
      if (n == 3) begin
        chk("R5 ifid held", ifid_instr, 32'h00090002);
        chk("R5 bubble", idex_instr, NOP_W);
      end
      if (n == 4) chk("R3 pc plus one", ifid_pcp1, 3);
      if (n == 9) chk("R3 offset sign extended", idex_offset, 32'hFFFFFFFF);
      if (n == 10) begin
        chk("R7 ifid flushed", ifid_instr, NOP_W);
        chk("R7 idex flushed", idex_instr, NOP_W);
        chk("R7 exmem flushed", exmem_instr, NOP_W);
      end
      if (n == 17) chk("R2 halt decoded in memwb", memwb_instr, 32'h01800000);
    end
    repeat (5) @(negedge clk);
    chk("R8 pc frozen", pc, 15);
    chk("R8 cycles frozen", cycles, 17);
    chk("R8 retired frozen", wbend_instr, 32'h00360007);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1 pc after rerun reset", pc, 0);
    chk("R1 halted cleared", {31'd0, halted}, 0);
    chk("R1 wbend noop", wbend_instr, NOP_W);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule